// File: doc/BRIEF.md
# Two-Stage Prescaled Watchdog Timer

This block is the countdown core of a watchdog that runs from a 33 MHz bus clock. Once enabled it times a first interval from its first preload. When that interval runs out it raises a selectable interrupt pulse and goes straight on to time a second interval from its second preload. When the second interval runs out it can pulse a system reset and set a sticky timeout flag. After that it either stops or, in free-run mode, starts again at the first stage.

Software keeps the system alive by strobing the reload input, which puts the count back to the start of the first stage. Each interval is the preload value times a prescale ratio. The ratio is 2^15 clocks on the slow scale and 2^5 clocks on the fast scale. Register decode and any unlock sequence sit outside this block. The block sees only the decoded control levels and strobes.

Top module: `wdt_two_stage`

## Requirements
- R1: Stage 1 is timed from `preload1_i` and stage 2 from `preload2_i`. `stage2_o` is 0 during stage 1 and 1 from the edge where stage 2 begins. It keeps its value while the count is stopped.
- R2: An interval lasts max(preload,1) × 2^15 clocks when `scale_fast_i`=0 and max(preload,1) × 2^5 clocks when `scale_fast_i`=1. The expiry edge falls that many clock edges after the edge on which the stage started.
- R3: At a stage-1 expiry, `irq_o` pulses for one cycle if `int_type_i`=2'b00 and `smi_o` pulses for one cycle if `int_type_i`=2'b10. No pulse is raised for 2'b01 or 2'b11. Stage 2 then starts.
- R4: At a stage-2 expiry with `reboot_en_i`=1, `sys_rst_o` pulses for one cycle and `timeout_flag_o` is set. If `free_run_i`=0 the count then stops, and no further pulse follows until a restart.
- R5: At a stage-2 expiry with `free_run_i`=1, the count restarts at stage 1 with a fresh preload-1 interval, whatever the value of `reboot_en_i`.
- R6: A reload strobe while enabled restarts stage 1 with a full preload-1 interval. A reload strobe while disabled has no effect.
- R7: A rising edge of `en_i` starts stage 1. While `en_i` is 0 the count is halted and no pulse is produced.
- R8: `timeout_flag_o` is cleared only by `flag_clr_i` or by `rst`, and not by the block's own `sys_rst_o`. If a set and a clear arrive in the same cycle, the set wins.
- R9: A preload of 0 times an interval of one prescaled tick.
- R10: While `rst` is high, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| en_i | input | 1 | Watchdog enable level |
| free_run_i | input | 1 | Restart at stage 1 after a stage-2 expiry |
| reload_i | input | 1 | Restart strobe (keep-alive) |
| flag_clr_i | input | 1 | Clears the timeout flag |
| scale_fast_i | input | 1 | 1: tick = 2^5 clocks, 0: tick = 2^15 clocks |
| int_type_i | input | 2 | Stage-1 interrupt select: 00 IRQ, 10 SMI, others none |
| reboot_en_i | input | 1 | Allow reset pulse and flag at stage-2 expiry |
| preload1_i | input | 20 | Stage-1 interval in ticks |
| preload2_i | input | 20 | Stage-2 interval in ticks |
| irq_o | output | 1 | One-cycle interrupt pulse |
| smi_o | output | 1 | One-cycle system-management interrupt pulse |
| sys_rst_o | output | 1 | One-cycle system reset pulse |
| stage2_o | output | 1 | Current stage: 0 first, 1 second |
| timeout_flag_o | output | 1 | Sticky flag: a watchdog reset occurred |

## Verification
Every output is a register. A stimulus sampled on a rising edge therefore shows at the outputs right after that edge. An expiry that lands N edges after a start edge shows up right after edge N, together with the change of `stage2_o`. Inputs are driven on falling edges. A behavioural model counts down the remaining cycles of the current interval and steps on each rising edge. The outputs are compared with it on every falling edge. Directed checks sample one cycle before and exactly at the due edge. This pins down both the fast and slow interval lengths and the preload-0 case.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    INT_IRQ  = 2'b00,
    INT_RSVD = 2'b01,
    INT_SMI  = 2'b10,
    INT_OFF  = 2'b11
  } int_sel_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PSC_W     = 15,
  parameter int FAST_LOG2 = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic clear_i,
  input  logic fast_i,
  output logic tick_o
);
  localparam logic [PSC_W-1:0] SLOW_TERM = {PSC_W{1'b1}};
  localparam logic [PSC_W-1:0] FAST_TERM = PSC_W'((1 << FAST_LOG2) - 1);

  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] term;

  always_comb begin
    term   = fast_i ? FAST_TERM : SLOW_TERM;
    tick_o = run_i && (psc_q >= term);
  end

  always_ff @(posedge clk) begin
    if (rst || !run_i || clear_i || tick_o) psc_q <= '0;
    else                                    psc_q <= psc_q + 1'b1;
  end
endmodule

// File: rtl/wdt_stage_ctrl.sv
module wdt_stage_ctrl #(
  parameter int PRE_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             reload_i,
  input  logic             free_run_i,
  input  logic             tick_i,
  input  logic [PRE_W-1:0] pre1_i,
  input  logic [PRE_W-1:0] pre2_i,
  output logic             run_o,
  output logic             stage2_o,
  output logic             restart_o,
  output logic             exp1_o,
  output logic             exp2_o
);
  localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

  logic [PRE_W-1:0] remain_q;
  logic             en_q;
  logic             start1;
  logic             last;

  function automatic logic [PRE_W-1:0] ticks_of(input logic [PRE_W-1:0] p);
    return (p == '0) ? ONE : p;
  endfunction

  always_comb begin
    start1    = en_i && (!en_q || reload_i);
    last      = run_o && tick_i && (remain_q <= ONE);
    exp1_o    = en_i && !start1 && last && !stage2_o;
    exp2_o    = en_i && !start1 && last && stage2_o;
    restart_o = start1 || exp1_o || (exp2_o && free_run_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      run_o    <= 1'b0;
      stage2_o <= 1'b0;
      remain_q <= '0;
    end else begin
      en_q <= en_i;
      if (!en_i) begin
        run_o <= 1'b0;
      end else if (start1) begin
        run_o    <= 1'b1;
        stage2_o <= 1'b0;
        remain_q <= ticks_of(pre1_i);
      end else if (exp1_o) begin
        stage2_o <= 1'b1;
        remain_q <= ticks_of(pre2_i);
      end else if (exp2_o) begin
        if (free_run_i) begin
          stage2_o <= 1'b0;
          remain_q <= ticks_of(pre1_i);
        end else begin
          run_o <= 1'b0;
        end
      end else if (run_o && tick_i) begin
        remain_q <= remain_q - 1'b1;
      end
    end
  end

  AST_HALT_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !run_o); // R7
  AST_STAGE2_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(stage2_o) |-> $past(run_o)); // R1
endmodule

// File: rtl/wdt_event_out.sv
module wdt_event_out
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       exp1_i,
  input  logic       exp2_i,
  input  logic [1:0] int_type_i,
  input  logic       reboot_en_i,
  input  logic       flag_clr_i,
  output logic       irq_o,
  output logic       smi_o,
  output logic       sys_rst_o,
  output logic       timeout_flag_o
);
  logic set_flag;

  always_comb set_flag = exp2_i && reboot_en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o          <= 1'b0;
      smi_o          <= 1'b0;
      sys_rst_o      <= 1'b0;
      timeout_flag_o <= 1'b0;
    end else begin
      irq_o     <= exp1_i && (int_type_i == INT_IRQ);
      smi_o     <= exp1_i && (int_type_i == INT_SMI);
      sys_rst_o <= set_flag;
      if (set_flag)        timeout_flag_o <= 1'b1;
      else if (flag_clr_i) timeout_flag_o <= 1'b0;
    end
  end

  AST_IRQ_SMI_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(irq_o && smi_o)); // R3
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |=> !sys_rst_o); // R4
  AST_RST_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |-> timeout_flag_o); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (timeout_flag_o && !flag_clr_i) |=> timeout_flag_o); // R8
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int PRE_W     = 20,
  parameter int PSC_W     = 15,
  parameter int FAST_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             free_run_i,
  input  logic             reload_i,
  input  logic             flag_clr_i,
  input  logic             scale_fast_i,
  input  logic [1:0]       int_type_i,
  input  logic             reboot_en_i,
  input  logic [PRE_W-1:0] preload1_i,
  input  logic [PRE_W-1:0] preload2_i,
  output logic             irq_o,
  output logic             smi_o,
  output logic             sys_rst_o,
  output logic             stage2_o,
  output logic             timeout_flag_o
);
  logic run, restart, tick, exp1, exp2;

  wdt_prescaler #(.PSC_W(PSC_W), .FAST_LOG2(FAST_LOG2)) u_psc (
    .clk(clk), .rst(rst), .run_i(run), .clear_i(restart),
    .fast_i(scale_fast_i), .tick_o(tick)
  );

  wdt_stage_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rst(rst), .en_i(en_i), .reload_i(reload_i),
    .free_run_i(free_run_i), .tick_i(tick), .pre1_i(preload1_i),
    .pre2_i(preload2_i), .run_o(run), .stage2_o(stage2_o),
    .restart_o(restart), .exp1_o(exp1), .exp2_o(exp2)
  );

  wdt_event_out u_evt (
    .clk(clk), .rst(rst), .exp1_i(exp1), .exp2_i(exp2),
    .int_type_i(int_type_i), .reboot_en_i(reboot_en_i),
    .flag_clr_i(flag_clr_i), .irq_o(irq_o), .smi_o(smi_o),
    .sys_rst_o(sys_rst_o), .timeout_flag_o(timeout_flag_o)
  );
endmodule

// File: tb/tb_wdt_two_stage.sv
`timescale 1ns/1ps
module tb_wdt_two_stage;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 0, free_run = 0, reload = 0, flag_clr = 0, fast = 1, reboot = 0;
  logic [1:0] itype = 2'b00;
  logic [19:0] pre1 = 20'd1, pre2 = 20'd1;
  logic irq, smi, srst, stg2, flag;

  always #2.5 clk = ~clk;

  wdt_two_stage dut (
    .clk(clk), .rst(rst), .en_i(en), .free_run_i(free_run), .reload_i(reload),
    .flag_clr_i(flag_clr), .scale_fast_i(fast), .int_type_i(itype),
    .reboot_en_i(reboot), .preload1_i(pre1), .preload2_i(pre2),
    .irq_o(irq), .smi_o(smi), .sys_rst_o(srst), .stage2_o(stg2),
    .timeout_flag_o(flag)
  );

  int tests = 0, fails = 0, cycles = 0;
  int n_irq = 0, n_smi = 0, n_rst = 0;
  bit done = 0, started = 0;

  // behavioural reference: remaining cycles of the current interval
  bit m_run, m_stg, m_enq, m_irq, m_smi, m_rst, m_flag;
  longint m_left;

  function automatic longint ivl(input logic [19:0] p, input logic f);
    longint t;
    t = (p == 0) ? 1 : longint'(p);
    return f ? t * 32 : t * 32768;
  endfunction

  always @(posedge clk) begin
    bit e1, e2;
    e1 = 0; e2 = 0;
    if (rst) begin
      m_run = 0; m_stg = 0; m_enq = 0; m_flag = 0; m_left = 0;
    end else begin
      if (!en) m_run = 0;
      else if (!m_enq || reload) begin
        m_run = 1; m_stg = 0; m_left = ivl(pre1, fast);
      end else if (m_run) begin
        if (m_left == 1) begin
          if (!m_stg) begin
            e1 = 1; m_stg = 1; m_left = ivl(pre2, fast);
          end else begin
            e2 = 1;
            if (free_run) begin m_stg = 0; m_left = ivl(pre1, fast); end
            else m_run = 0;
          end
        end else m_left = m_left - 1;
      end
      if (e2 && reboot) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      m_enq = en;
    end
    m_irq = e1 && itype == 2'b00;
    m_smi = e1 && itype == 2'b10;
    m_rst = e2 && reboot;
    started = 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      check(irq == m_irq && smi == m_smi, "R3 irq/smi vs model", {irq, smi}, {m_irq, m_smi});
      check(srst == m_rst, "R4 sys_rst vs model", srst, m_rst);
      check(stg2 == m_stg, "R1 stage vs model", stg2, m_stg);
      check(flag == m_flag, "R8 flag vs model", flag, m_flag);
      n_irq += irq; n_smi += smi; n_rst += srst;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic zero_counts();
    n_irq = 0; n_smi = 0; n_rst = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      finish_run();
    end
  end

  initial begin
    cyc(3);
    check({irq, smi, srst, stg2, flag} == 5'b0, "R10 reset outputs", {irq, smi, srst, stg2, flag}, 0);
    rst = 0;
    // A: IRQ, reboot, no free run, fast scale
    pre1 = 3; pre2 = 2; fast = 1; itype = 2'b00; reboot = 1; free_run = 0;
    cyc(1); zero_counts();
    en = 1;
    cyc(96);
    check(irq == 0 && stg2 == 0, "R2 one cycle before stage-1 expiry", irq, 0);
    cyc(1);
    check(irq == 1, "R2 irq at 3*32 edges", irq, 1);
    check(stg2 == 1, "R1 stage 2 entered", stg2, 1);
    cyc(80);
    check(n_irq == 1 && n_rst == 1, "R4 one reset pulse", n_rst, 1);
    check(flag == 1, "R4 flag set", flag, 1);
    cyc(300);
    check(n_irq == 1 && n_rst == 1, "R4 count stopped", n_irq + n_rst, 2);
    check(flag == 1, "R8 flag survives own reset", flag, 1);
    flag_clr = 1; cyc(1); flag_clr = 0;
    check(flag == 0, "R8 flag cleared", flag, 0);
    // B: SMI, free run, no reboot
    en = 0; cyc(2);
    itype = 2'b10; reboot = 0; free_run = 1; pre1 = 2; pre2 = 1;
    zero_counts(); en = 1;
    cyc(202);
    check(n_smi == 2, "R5 two free-run loops", n_smi, 2);
    check(n_irq == 0 && n_rst == 0, "R3 smi only", n_irq + n_rst, 0);
    // C: disable halts, reload while disabled ignored
    en = 0; cyc(2); zero_counts();
    cyc(300);
    check(n_smi + n_irq + n_rst == 0, "R7 halted while disabled", n_smi, 0);
    reload = 1; cyc(1); reload = 0;
    cyc(300);
    check(n_smi + n_irq + n_rst == 0, "R6 reload ignored when disabled", n_smi, 0);
    // D: no interrupt type
    itype = 2'b11; free_run = 0; pre1 = 1; pre2 = 1; zero_counts();
    en = 1; cyc(100);
    check(n_irq + n_smi == 0, "R3 type 11 silent", n_irq + n_smi, 0);
    check(stg2 == 1, "R1 stage held after stop", stg2, 1);
    // E: reload keeps it alive
    en = 0; cyc(2);
    itype = 2'b00; reboot = 1; pre1 = 3; pre2 = 3; zero_counts();
    en = 1;
    for (int i = 0; i < 10; i++) begin
      cyc(60); reload = 1; cyc(1); reload = 0;
    end
    check(n_irq == 0 && n_rst == 0, "R6 reloads prevent expiry", n_irq, 0);
    cyc(200);
    check(n_irq == 1 && n_rst == 1, "R6 expiry after reloads stop", n_irq + n_rst, 2);
    flag_clr = 1; cyc(1); flag_clr = 0;
    // F: preload zero
    en = 0; cyc(2);
    pre1 = 0; pre2 = 0; reboot = 0; zero_counts();
    en = 1; cyc(32);
    check(irq == 0, "R9 before one tick", irq, 0);
    cyc(1);
    check(irq == 1, "R9 irq after one tick", irq, 1);
    // G: slow scale, set wins over held clear
    en = 0; cyc(2);
    fast = 0; pre1 = 1; pre2 = 0; reboot = 1; flag_clr = 1;
    en = 1; cyc(32768);
    check(irq == 0, "R2 slow scale before expiry", irq, 0);
    cyc(1);
    check(irq == 1, "R2 slow scale 2^15 interval", irq, 1);
    cyc(32767);
    check(srst == 0, "R2 slow stage 2 not yet", srst, 0);
    cyc(1);
    check(srst == 1 && flag == 1, "R8 set wins over clear", flag, 1);
    cyc(1);
    check(flag == 0, "R8 held clear then clears", flag, 0);
    flag_clr = 0;
    cyc(5);
    finish_run();
  end
endmodule